// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Accumulator Commands

This block is a signed 24-by-24 multiply-accumulate engine that sits beside a 16-bit processor datapath. It holds a 48-bit accumulator and runs one command at a time. An 8-bit command code selects the command: clear, load at 32 or 48 bits, store at 32 or 48 bits, or multiply-accumulate. Each command costs a fixed number of clock cycles, and the unit pulses `done` when the command finishes.

A command and its 48-bit operand word enter through a valid/ready handshake. `cmd_ready` is the inverse of `busy`, so while a command runs the unit accepts nothing. Store results leave through a valid/ready output. When the consumer holds `out_ready` low, the final cycle of the store stretches: `out_valid` and `out_data` stay fixed and `done` waits. With `out_ready` held high, every command completes in exactly its listed cost.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset the accumulator is zero, `busy`, `done`, `out_valid` and `illegal` are low, and `cmd_ready` is high.
- R2: Code 0x00 (clear) sets the accumulator to zero and pulses `done` in the 4th cycle after acceptance.
- R3: Code 0x05 (load-32) writes `cmd_data[31:0]` into accumulator bits 47:16 and zeroes bits 15:0. `done` comes in the 9th cycle.
- R4: Code 0x07 (load-48) writes `cmd_data[47:0]` into the accumulator. `done` comes in the 9th cycle.
- R5: Code 0x08 (store-32) presents accumulator bits 47:16 on `out_data[31:0]`, with `out_data[47:32]` zero. `done` comes in the 7th cycle, and the accumulator is unchanged.
- R6: Code 0x04 (store-48) presents the whole accumulator on `out_data`. `done` comes in the 11th cycle, and the accumulator is unchanged.
- R7: Code 0x02 (multiply-accumulate) adds the two's-complement product of `cmd_data[23:0]` and `cmd_data[47:24]` to the accumulator, modulo 2^48 with no saturation. `done` comes in the 8th cycle.
- R8: `busy` is high from the cycle after acceptance through the `done` cycle, and `cmd_ready` equals `!busy`. A command presented while `busy` is high is not accepted and has no effect.
- R9: Any other code completes in 4 cycles, leaves the accumulator unchanged, and raises `illegal` together with `done`.
- R10: During a store, `out_valid` is high in the final cycle. While `out_ready` is low, `out_valid` and `out_data` hold and `done` stays low. `done` rises in the cycle in which `out_ready` is high.
- R11: `done` is a single-cycle pulse for each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle; the command is accepted when this and `cmd_valid` are both high |
| cmd_opc | input | 8 | Command code |
| cmd_data | input | 48 | Operand word: the load value, or the multiplier operands (A in 23:0, B in 47:24) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with `done` when the code was unknown |
| out_valid | output | 1 | Store result present |
| out_ready | input | 1 | Consumer accepts the store result |
| out_data | output | 48 | Store result |

## Verification
The hardest situation to reach is a command offered while another one is running. From outside, it looks like an accepted command only if the handshake rule is broken. To reach it, the stimulus starts a load and raises `cmd_valid` with a different value partway through `busy`. It drops `cmd_valid` before `busy` falls, then stores the accumulator to show that only the first value landed. The stalled store is reached by holding `out_ready` low through the last cycle of a store-48, which checks that the output holds and that `done` is deferred. The wrap case is reached by loading the largest positive 48-bit value and adding a product of one.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    K_CLR, K_MAC, K_ST48, K_LD32, K_LD48, K_ST32, K_BAD
  } kind_e;

  localparam logic [7:0] OPC_CLR  = 8'h00;
  localparam logic [7:0] OPC_MAC  = 8'h02;
  localparam logic [7:0] OPC_ST48 = 8'h04;
  localparam logic [7:0] OPC_LD32 = 8'h05;
  localparam logic [7:0] OPC_LD48 = 8'h07;
  localparam logic [7:0] OPC_ST32 = 8'h08;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int C_CLR   = 4,
  parameter int C_MAC   = 8,
  parameter int C_ST48  = 11,
  parameter int C_LD32  = 9,
  parameter int C_LD48  = 9,
  parameter int C_ST32  = 7,
  parameter int C_BAD   = 4
) (
  input  logic [7:0]       opc,
  output kind_e            kind,
  output logic [CNT_W-1:0] cost
);
  always_comb begin
    unique case (opc)
      OPC_CLR:  begin kind = K_CLR;  cost = CNT_W'(C_CLR);  end
      OPC_MAC:  begin kind = K_MAC;  cost = CNT_W'(C_MAC);  end
      OPC_ST48: begin kind = K_ST48; cost = CNT_W'(C_ST48); end
      OPC_LD32: begin kind = K_LD32; cost = CNT_W'(C_LD32); end
      OPC_LD48: begin kind = K_LD48; cost = CNT_W'(C_LD48); end
      OPC_ST32: begin kind = K_ST32; cost = CNT_W'(C_ST32); end
      default:  begin kind = K_BAD;  cost = CNT_W'(C_BAD);  end
    endcase
  end
endmodule

// File: rtl/mac_seq.sv
module mac_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cost,
  input  logic             stall,
  output logic             busy,
  output logic             last,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign last = (cnt == CNT_W'(1));
  assign done = last && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= cost;
    else if (busy && !(last && stall))
      cnt <= cnt - CNT_W'(1);
  end

  // R11: done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: busy stays up until done
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R8: no new start while busy
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W    = 24,
  parameter int SHORT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  kind_e               kind_in,
  input  logic [2*OP_W-1:0]   data_in,
  input  logic                apply,
  output kind_e               kind_q,
  output logic [2*OP_W-1:0]   acc
);
  localparam int ACC_W = 2 * OP_W;
  localparam int LOW_W = ACC_W - SHORT_W;

  logic [ACC_W-1:0]        data_q;
  logic signed [OP_W-1:0]  op_a, op_b;
  logic signed [ACC_W-1:0] prod;

  assign op_a = data_q[OP_W-1:0];
  assign op_b = data_q[ACC_W-1:OP_W];
  assign prod = op_a * op_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_CLR;
      data_q <= '0;
    end else if (capture) begin
      kind_q <= kind_in;
      data_q <= data_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc <= '0;
    else if (apply) begin
      case (kind_q)
        K_CLR:  acc <= '0;
        K_MAC:  acc <= acc + prod;
        K_LD32: acc <= {data_q[SHORT_W-1:0], {LOW_W{1'b0}}};
        K_LD48: acc <= data_q;
        default: acc <= acc;
      endcase
    end
  end

  // R2: clear leaves zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && kind_q == K_CLR) |=> (acc == '0));
  // R4: full-width load copies operand word
  a_r4_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && kind_q == K_LD48) |=> (acc == $past(data_q)));
  // R3: short load clears low bits
  a_r3_load_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && kind_q == K_LD32) |=> (acc[LOW_W-1:0] == '0));
  // R5 R6 R9: stores and unknown codes keep the accumulator
  a_r6_keep_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && (kind_q == K_ST32 || kind_q == K_ST48 || kind_q == K_BAD))
      |=> $stable(acc));
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int OP_W    = 24,
  parameter int SHORT_W = 32,
  parameter int C_CLR   = 4,
  parameter int C_MAC   = 8,
  parameter int C_ST48  = 11,
  parameter int C_LD32  = 9,
  parameter int C_LD48  = 9,
  parameter int C_ST32  = 7,
  parameter int C_BAD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opc,
  input  logic [2*OP_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*OP_W-1:0] out_data
);
  localparam int ACC_W = 2 * OP_W;
  localparam int LOW_W = ACC_W - SHORT_W;
  localparam int MAXC  = imax(imax(imax(C_CLR, C_MAC), imax(C_ST48, C_LD32)),
                              imax(imax(C_LD48, C_ST32), C_BAD));
  localparam int CNT_W = $clog2(MAXC + 1);

  kind_e            dec_kind, kind_q;
  logic [CNT_W-1:0] dec_cost;
  logic [ACC_W-1:0] acc;
  logic             start, last, stall, is_store;

  assign cmd_ready = !busy;
  assign start     = cmd_valid && cmd_ready;
  assign is_store  = (kind_q == K_ST32) || (kind_q == K_ST48);
  assign out_valid = last && is_store;
  assign stall     = out_valid && !out_ready;
  assign illegal   = done && (kind_q == K_BAD);

  always_comb begin
    if (!out_valid)
      out_data = '0;
    else if (kind_q == K_ST48)
      out_data = acc;
    else
      out_data = {{LOW_W{1'b0}}, acc[ACC_W-1:LOW_W]};
  end

  mac_decode #(
    .CNT_W(CNT_W), .C_CLR(C_CLR), .C_MAC(C_MAC), .C_ST48(C_ST48),
    .C_LD32(C_LD32), .C_LD48(C_LD48), .C_ST32(C_ST32), .C_BAD(C_BAD)
  ) u_dec (
    .opc  (cmd_opc),
    .kind (dec_kind),
    .cost (dec_cost)
  );

  mac_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cost  (dec_cost),
    .stall (stall),
    .busy  (busy),
    .last  (last),
    .done  (done)
  );

  mac_datapath #(.OP_W(OP_W), .SHORT_W(SHORT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (start),
    .kind_in (dec_kind),
    .data_in (cmd_data),
    .apply   (done),
    .kind_q  (kind_q),
    .acc     (acc)
  );

  // R10: stalled store output holds
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R10: no done while output is stalled
  a_r10_no_done_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !done);
  // R9: illegal only comes with done
  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && busy));
endmodule

// File: tb/mac_acc_unit_tb.sv
module mac_acc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opc = 8'h00;
  logic [47:0] cmd_data = '0;
  logic        busy, done, illegal, out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] out_data;

  int total = 0;
  int bad = 0;
  logic [47:0] macc = '0;

  always #5 clk = ~clk;

  mac_acc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opc(cmd_opc), .cmd_data(cmd_data), .busy(busy), .done(done),
    .illegal(illegal), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer a command, wait for acceptance, count cycles to done.
  task automatic run_cmd(input logic [7:0] opc, input logic [47:0] d,
                         output int lat, output logic [47:0] od, output bit ill);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opc = opc; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    od = out_data;
    ill = illegal;
  endtask

  function automatic logic [47:0] prod48(input logic [23:0] a, input logic [23:0] b);
    longint sa, sb;
    sa = {{40{a[23]}}, a};
    sb = {{40{b[23]}}, b};
    return 48'(sa * sb);
  endfunction

  task automatic read48(input string req, input logic [47:0] exp);
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h04, '0, lat, od, ill);
    chk(od == exp, req, od, exp);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !out_valid && !illegal && cmd_ready, "R1 idle outputs",
        {busy, done, out_valid, illegal, cmd_ready}, 5'b00001);
    read48("R1 acc zero", '0);
  endtask

  task automatic t_load_clear;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h07, 48'h1234_5678_9ABC, lat, od, ill);
    macc = 48'h1234_5678_9ABC;
    chk(lat == 9, "R4 load48 cycles", lat, 9);
    read48("R4 load48 value", macc);
    run_cmd(8'h00, 48'hFFFF_FFFF_FFFF, lat, od, ill);
    macc = '0;
    chk(lat == 4, "R2 clear cycles", lat, 4);
    read48("R2 clear value", macc);
  endtask

  task automatic t_load32;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h05, 48'hAAAA_8765_4321, lat, od, ill);
    macc = 48'h8765_4321_0000;
    chk(lat == 9, "R3 load32 cycles", lat, 9);
    read48("R3 load32 value", macc);
  endtask

  task automatic t_stores;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h08, '0, lat, od, ill);
    chk(lat == 7, "R5 store32 cycles", lat, 7);
    chk(od == {16'h0, macc[47:16]}, "R5 store32 data", od, {16'h0, macc[47:16]});
    run_cmd(8'h04, '0, lat, od, ill);
    chk(lat == 11, "R6 store48 cycles", lat, 11);
    chk(od == macc, "R6 store48 data", od, macc);
    read48("R6 acc kept after stores", macc);
  endtask

  task automatic t_mac;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h00, '0, lat, od, ill);
    macc = '0;
    run_cmd(8'h02, {24'hFFFFFB, 24'h000003}, lat, od, ill);
    macc = macc + prod48(24'h000003, 24'hFFFFFB);
    chk(lat == 8, "R7 mac cycles", lat, 8);
    read48("R7 mac signed product", macc);
    run_cmd(8'h02, {24'h800000, 24'h800000}, lat, od, ill);
    macc = macc + prod48(24'h800000, 24'h800000);
    read48("R7 mac most negative squared", macc);
    run_cmd(8'h02, {24'h7FFFFF, 24'h800000}, lat, od, ill);
    macc = macc + prod48(24'h800000, 24'h7FFFFF);
    read48("R7 mac mixed sign", macc);
  endtask

  task automatic t_wrap;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h07, 48'h7FFF_FFFF_FFFF, lat, od, ill);
    run_cmd(8'h02, {24'h000001, 24'h000001}, lat, od, ill);
    read48("R7 wraps without saturation", 48'h8000_0000_0000);
    macc = 48'h8000_0000_0000;
  endtask

  task automatic t_busy_ignore;
    int lat; logic [47:0] od; bit ill;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opc = 8'h07; cmd_data = 48'h0000_1111_2222;
    @(negedge clk);
    cmd_opc = 8'h07; cmd_data = 48'h0000_DEAD_BEEF;
    lat = 1;
    repeat (3) begin
      chk(busy && !cmd_ready, "R8 busy while running", {busy, cmd_ready}, 2'b10);
      @(negedge clk);
      lat++;
    end
    cmd_valid = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == 9, "R8 first command timing", lat, 9);
    @(negedge clk);
    chk(!busy && cmd_ready, "R8 idle after done", {busy, cmd_ready}, 2'b01);
    macc = 48'h0000_1111_2222;
    read48("R8 command during busy ignored", macc);
  endtask

  task automatic t_illegal;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h03, 48'hFFFF_FFFF_FFFF, lat, od, ill);
    chk(lat == 4, "R9 unknown cycles", lat, 4);
    chk(ill, "R9 illegal flag", ill, 1);
    read48("R9 acc unchanged", macc);
    run_cmd(8'h05 + 8'h80, '0, lat, od, ill);
    chk(ill && lat == 4, "R9 high-bit code illegal", lat, 4);
    run_cmd(8'h08, '0, lat, od, ill);
    chk(!ill, "R9 no flag on legal code", ill, 0);
  endtask

  task automatic t_backpressure;
    logic [47:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    cmd_valid = 1'b1; cmd_opc = 8'h04; cmd_data = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(out_valid && !done, "R10 valid without done", {out_valid, done}, 2'b10);
    held = out_data;
    chk(held == macc, "R10 data presented", held, macc);
    repeat (3) begin
      @(negedge clk);
      chk(out_valid && !done && out_data == held, "R10 stall holds", out_data, held);
    end
    out_ready = 1'b1;
    #1;
    chk(done, "R10 done on accept", done, 1);
    @(negedge clk);
    chk(!done && !busy && !out_valid, "R11 single pulse", {done, busy, out_valid}, 3'b000);
  endtask

  task automatic t_done_pulse;
    int lat; logic [47:0] od; bit ill;
    run_cmd(8'h00, '0, lat, od, ill);
    macc = '0;
    @(negedge clk);
    chk(!done, "R11 done drops after one cycle", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_clear();
    t_load32();
    t_stores();
    t_mac();
    t_wrap();
    t_busy_ignore();
    t_illegal();
    t_backpressure();
    t_done_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule